// File: doc/BRIEF.md
# Processor Tick Countdown Timer

This block is a memory-mapped periodic down-counter that gives a processor core a regular time base. Software programs a 24-bit reload value and turns the counter on. The counter then steps down once per selected tick, either every core clock cycle or on each strobe of a slower reference tick. Each time it reaches zero it sets a sticky wrap flag and, if enabled, drives a one-cycle interrupt request. On the following tick it reloads and starts the next period.

Software reaches the block through a small word-only register port. Each request carries a privilege attribute and a size. Every request gets a registered response one cycle later. Rejected requests return an error response and change nothing.

A three-state counter machine runs the count:
- STOPPED: the counter is off and holds zero.
- COUNTING: a non-zero count steps down on each tick.
- AT_ZERO: the count is zero and waits for the next tick to reload.

The transitions are:
- START: enable rises; the counter loads the reload value.
- STOP: enable falls.
- STEP: a tick decrements a count above one.
- EXPIRE: a tick takes the count from one to zero; this sets the flag and may fire the interrupt.
- REFILL: a tick in AT_ZERO loads the reload value.
- SOURCE_SWITCH: the clock source changes while enabled; the counter reloads.
- CLEAR: any write to the current-value register moves the counter to AT_ZERO.

Top module: `cpu_tick_timer`

## Requirements
- R1: After reset the control/status word (offset 0x0), the reload register (0x4) and the current value (0x8) all read 0, and `irq` is low.
- R2: A write to control/status (0x0) changes only bit 0 (enable), bit 1 (interrupt enable) and bit 2 (source: 1 = core clock, 0 = reference tick). Bit 16 is the wrap flag and cannot be written. All other bits read 0.
- R3: When enable rises, the current value becomes the reload value. It then drops by one per selected tick. A full period lasts reload+1 ticks: reload down to 0, then back to reload.
- R4: On the tick that takes the count from 1 to 0, the wrap flag (bit 16 of offset 0x0) is set. `irq` is high for exactly the next cycle if interrupt enable was 1, and stays low otherwise.
- R5: A read of offset 0x0 returns the wrap flag and clears it in the same access. A second read returns it as 0.
- R6: Any write to offset 0x8, whatever the data, sets the count to 0 and clears the wrap flag. The next tick reloads the count without setting the flag.
- R7: While enable is 0, offset 0x8 reads 0.
- R8: With source 0 the count moves only on `ref_tick` strobes. With source 1 it moves every cycle. Changing the source while enabled reloads the count.
- R9: A request with `req_priv` low, or with `req_size` other than 2 (word), gets `rsp_err` = 1 and read data 0. It leaves every register unchanged.
- R10: Accesses to offsets other than 0x0, 0x4, 0x8 and 0xC get no error. Such writes change nothing, and such reads return 0.
- R11: The reload and current values are 24 bits wide, and bits [31:24] read 0. With reload 0 the running counter stays at 0 and never sets the flag or raises `irq`.
- R12: Offset 0xC reads the parameter `CALIB_VALUE`.
- R13: Every request is answered by exactly one `rsp_valid` pulse in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Single-cycle reference tick strobe, synchronous to clk |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_size | input | 2 | Access size code; 2 = 32-bit word |
| req_priv | input | 1 | 1 = privileged access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_err | output | 1 | Error response for a rejected request |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | One-cycle interrupt request on a wrap |

## Verification
The bench builds the block with the default 24-bit counter and 8-bit offset space, and a non-zero calibration constant so that the read path is not trivially zero. The width choice puts the truncation of bits [31:24] on reload writes within reach. Small reload values, together with manually strobed reference ticks, step the count one value at a time. Short core-clock runs then show that a source switch reloads the count and that a zero reload never wraps.

// File: rtl/ctt_pkg.sv
package ctt_pkg;

    localparam int unsigned WORD_W = 32;

    localparam int unsigned OFS_STATUS  = 'h0;
    localparam int unsigned OFS_RELOAD  = 'h4;
    localparam int unsigned OFS_CURRENT = 'h8;
    localparam int unsigned OFS_CALIB   = 'hC;

    localparam int unsigned FLAG_BIT = 16;

    localparam logic [1:0] SIZE_WORD = 2'd2;

    typedef enum logic [1:0] {
        CNT_STOPPED = 2'd0,
        CNT_COUNTING = 2'd1,
        CNT_AT_ZERO = 2'd2
    } cnt_state_e;

    typedef struct packed {
        logic src_core;
        logic irq_en;
        logic enable;
    } ctrl_t;

endpackage

// File: rtl/ctt_bus_regs.sv
module ctt_bus_regs
    import ctt_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned CNT_W       = 24,
    parameter logic [31:0] CALIB_VALUE = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_priv,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  cur_count,
    input  logic              wrap_evt,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [WORD_W-1:0] rsp_rdata,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload_val,
    output logic              wrap_flag,
    output logic              cmd_enable_rise,
    output logic              cmd_disable,
    output logic              cmd_src_change,
    output logic              cmd_cur_clear
);

    localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_RELOAD  = ADDR_W'(OFS_RELOAD);
    localparam logic [ADDR_W-1:0] A_CURRENT = ADDR_W'(OFS_CURRENT);
    localparam logic [ADDR_W-1:0] A_CALIB   = ADDR_W'(OFS_CALIB);

    logic        acc_ok, acc_bad, wr_ok, rd_ok;
    logic        hit_status, hit_reload, hit_current, hit_calib;
    ctrl_t       ctrl_new;
    logic [WORD_W-1:0] rd_word, status_word;
    logic        unused_wdata;

    assign acc_ok  = req_valid && req_priv && (req_size == SIZE_WORD);
    assign acc_bad = req_valid && !acc_ok;
    assign wr_ok   = acc_ok && req_write;
    assign rd_ok   = acc_ok && !req_write;

    assign hit_status  = (req_addr == A_STATUS);
    assign hit_reload  = (req_addr == A_RELOAD);
    assign hit_current = (req_addr == A_CURRENT);
    assign hit_calib   = (req_addr == A_CALIB);

    assign ctrl_new     = ctrl_t'(req_wdata[2:0]);
    assign unused_wdata = ^req_wdata[WORD_W-1:CNT_W];

    // Commands handed to the counter machine
    assign cmd_enable_rise = wr_ok && hit_status && ctrl_new.enable && !ctrl.enable;
    assign cmd_disable     = wr_ok && hit_status && !ctrl_new.enable && ctrl.enable;
    assign cmd_src_change  = wr_ok && hit_status && ctrl_new.enable && ctrl.enable
                             && (ctrl_new.src_core != ctrl.src_core);
    assign cmd_cur_clear   = wr_ok && hit_current;

    always_comb begin
        status_word           = '0;
        status_word[2:0]      = ctrl;
        status_word[FLAG_BIT] = wrap_flag;
    end

    always_comb begin
        rd_word = '0;
        if (hit_status) begin
            rd_word = status_word;
        end else if (hit_reload) begin
            rd_word = WORD_W'(reload_val);
        end else if (hit_current) begin
            rd_word = ctrl.enable ? WORD_W'(cur_count) : '0;
        end else if (hit_calib) begin
            rd_word = CALIB_VALUE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl       <= '0;
            reload_val <= '0;
        end else begin
            if (wr_ok && hit_status) begin
                ctrl <= ctrl_new;
            end
            if (wr_ok && hit_reload) begin
                reload_val <= req_wdata[CNT_W-1:0];
            end
        end
    end

    // A wrap in the same cycle as a clearing access wins, so no wrap is lost
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_flag <= 1'b0;
        end else if (wrap_evt) begin
            wrap_flag <= 1'b1;
        end else if ((rd_ok && hit_status) || cmd_cur_clear) begin
            wrap_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= acc_bad;
            rsp_rdata <= rd_ok ? rd_word : '0;
        end
    end

endmodule

// File: rtl/ctt_counter.sv
module ctt_counter
    import ctt_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             cmd_enable_rise,
    input  logic             cmd_disable,
    input  logic             cmd_src_change,
    input  logic             cmd_cur_clear,
    output logic [CNT_W-1:0] count,
    output logic             wrap_evt,
    output logic             irq
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_d;
    logic             tick;
    cnt_state_e       load_state;

    assign tick       = ctrl.src_core ? 1'b1 : ref_tick;
    assign load_state = (reload_val == '0) ? CNT_AT_ZERO : CNT_COUNTING;

    always_comb begin
        state_d  = state_q;
        count_d  = count;
        wrap_evt = 1'b0;
        if (cmd_disable) begin
            state_d = CNT_STOPPED;                  // STOP
            count_d = '0;
        end else if (cmd_enable_rise || cmd_src_change) begin
            state_d = load_state;                   // START / SOURCE_SWITCH
            count_d = reload_val;
        end else if (cmd_cur_clear && state_q != CNT_STOPPED) begin
            state_d = CNT_AT_ZERO;                  // CLEAR
            count_d = '0;
        end else if (tick) begin
            unique case (state_q)
                CNT_STOPPED: begin
                    count_d = '0;
                end
                CNT_COUNTING: begin
                    if (count == ONE) begin
                        state_d  = CNT_AT_ZERO;     // EXPIRE
                        count_d  = '0;
                        wrap_evt = 1'b1;
                    end else begin
                        count_d = count - ONE;      // STEP
                    end
                end
                CNT_AT_ZERO: begin
                    state_d = load_state;           // REFILL
                    count_d = reload_val;
                end
                default: begin
                    state_d = CNT_STOPPED;
                    count_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CNT_STOPPED;
            count   <= '0;
        end else begin
            state_q <= state_d;
            count   <= count_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= wrap_evt && ctrl.irq_en;
        end
    end

endmodule

// File: rtl/cpu_tick_timer.sv
module cpu_tick_timer
    import ctt_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned CNT_W       = 24,
    parameter logic [31:0] CALIB_VALUE = 32'h4000_2710
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_priv,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              irq
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] cur_count;
    logic             wrap_flag;
    logic             wrap_evt;
    logic             cmd_enable_rise, cmd_disable, cmd_src_change, cmd_cur_clear;

    ctt_bus_regs #(
        .ADDR_W(ADDR_W),
        .CNT_W(CNT_W),
        .CALIB_VALUE(CALIB_VALUE)
    ) regs_i (
        .clk(clk),
        .rst_n(rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr(req_addr),
        .req_size(req_size),
        .req_priv(req_priv),
        .req_wdata(req_wdata),
        .cur_count(cur_count),
        .wrap_evt(wrap_evt),
        .rsp_valid(rsp_valid),
        .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata),
        .ctrl(ctrl),
        .reload_val(reload_val),
        .wrap_flag(wrap_flag),
        .cmd_enable_rise(cmd_enable_rise),
        .cmd_disable(cmd_disable),
        .cmd_src_change(cmd_src_change),
        .cmd_cur_clear(cmd_cur_clear)
    );

    ctt_counter #(
        .CNT_W(CNT_W)
    ) cnt_i (
        .clk(clk),
        .rst_n(rst_n),
        .ref_tick(ref_tick),
        .ctrl(ctrl),
        .reload_val(reload_val),
        .cmd_enable_rise(cmd_enable_rise),
        .cmd_disable(cmd_disable),
        .cmd_src_change(cmd_src_change),
        .cmd_cur_clear(cmd_cur_clear),
        .count(cur_count),
        .wrap_evt(wrap_evt),
        .irq(irq)
    );

endmodule

// File: rtl/ctt_checker.sv
module ctt_checker #(
    parameter int unsigned CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_size,
    input logic             req_priv,
    input logic             rsp_valid,
    input logic             irq,
    input logic [2:0]       ctrl_bits,
    input logic [CNT_W-1:0] reload_val,
    input logic [CNT_W-1:0] cur_count,
    input logic             wrap_flag
);

    assert_rsp_follows_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_stray_rsp_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_irq_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ctrl_bits[1]));

    assert_irq_with_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> wrap_flag);

    assert_stopped_is_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_bits[0] |-> (cur_count == '0));

    assert_rejected_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (!req_priv || req_size != 2'd2))
        |=> ($stable(ctrl_bits) && $stable(reload_val)));

endmodule

bind cpu_tick_timer ctt_checker #(
    .CNT_W(CNT_W)
) chk_i (
    .clk(clk),
    .rst_n(rst_n),
    .req_valid(req_valid),
    .req_size(req_size),
    .req_priv(req_priv),
    .rsp_valid(rsp_valid),
    .irq(irq),
    .ctrl_bits(ctrl),
    .reload_val(reload_val),
    .cur_count(cur_count),
    .wrap_flag(wrap_flag)
);

// File: tb/cpu_tick_timer_tb_top.sv
`timescale 1ns/1ps
module cpu_tick_timer_tb_top;

    localparam logic [31:0] CALIB = 32'h4000_2710;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = 2'd2;
    logic        req_priv = 1'b1;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, irq;
    logic [31:0] rsp_rdata;

    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        logic [31:0] rdata;
        logic        err;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    cpu_tick_timer #(.ADDR_W(8), .CNT_W(24), .CALIB_VALUE(CALIB)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_priv(req_priv), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Monitor: compare every response against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R13 unexpected response", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check((rsp_rdata === e.rdata) && (rsp_err === e.err), e.tag,
                      {rsp_err, rsp_rdata[30:0]}, {e.err, e.rdata[30:0]});
                if (rsp_rdata[31] !== e.rdata[31])
                    check(1'b0, e.tag, rsp_rdata, e.rdata);
            end
        end
    end

    // Driver: one request per cycle, starting at a falling edge
    task automatic bus_op(input logic wr, input logic [7:0] addr, input logic [31:0] wd,
                          input logic [1:0] size, input logic priv,
                          input logic [31:0] exp_rd, input logic exp_err, input string tag);
        exp_t e;
        e.rdata = exp_rd;
        e.err   = exp_err;
        e.tag   = tag;
        exp_q.push_back(e);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_wdata = wd;
        req_size  = size;
        req_priv  = priv;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_size  = 2'd2;
        req_priv  = 1'b1;
    endtask

    task automatic wr32(input logic [7:0] a, input logic [31:0] d, input string tag);
        bus_op(1'b1, a, d, 2'd2, 1'b1, 32'h0, 1'b0, tag);
    endtask

    task automatic rd32(input logic [7:0] a, input logic [31:0] expv, input string tag);
        bus_op(1'b0, a, 32'h0, 2'd2, 1'b1, expv, 1'b0, tag);
    endtask

    task automatic tick_once(input logic exp_irq, input string tag);
        ref_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ref_tick = 1'b0;
        check(irq === exp_irq, tag, {31'h0, irq}, {31'h0, exp_irq});
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) tick_once(1'b0, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R13 watchdog expired", 32'h1, 32'h0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check(irq === 1'b0, "R1 irq low after reset", {31'h0, irq}, 32'h0);
        rd32(8'h00, 32'h0, "R1 status after reset");
        rd32(8'h04, 32'h0, "R1 reload after reset");
        rd32(8'h08, 32'h0, "R1 current after reset");
        rd32(8'h0C, CALIB, "R12 calibration value");

        wr32(8'h04, 32'hFFFF_FF05, "R11 reload write wide");
        rd32(8'h04, 32'h00FF_FF05, "R11 reload upper bits zero");
        wr32(8'h04, 32'h0A00_0005, "R11 reload write");
        rd32(8'h04, 32'h0000_0005, "R11 reload readback");

        wr32(8'h00, 32'hFFFF_FFF8, "R2 write upper bits only");
        rd32(8'h00, 32'h0, "R2 upper bits ignored");
        wr32(8'h00, 32'h0001_0006, "R2 write with flag bit");
        rd32(8'h00, 32'h6, "R2 flag not writable");
        wr32(8'h00, 32'h2, "R2 ie only, reference source");
        rd32(8'h08, 32'h0, "R7 current while disabled");

        // Start in reference-tick mode with interrupts on
        wr32(8'h00, 32'h3, "R3 enable");
        rd32(8'h08, 32'h5, "R3 loaded on enable");
        ticks(2, "R3 no irq while counting");
        rd32(8'h08, 32'h3, "R3 two steps down");
        ticks(2, "R3 no irq while counting");
        rd32(8'h08, 32'h1, "R3 four steps down");
        tick_once(1'b1, "R4 irq pulse on wrap");
        @(negedge clk);
        check(irq === 1'b0, "R4 irq lasts one cycle", {31'h0, irq}, 32'h0);
        rd32(8'h08, 32'h0, "R3 count at zero");
        rd32(8'h00, 32'h0001_0003, "R5 flag read as set");
        rd32(8'h00, 32'h0000_0003, "R5 flag cleared by read");
        tick_once(1'b0, "R3 refill without irq");
        rd32(8'h08, 32'h5, "R3 period reload+1 ticks");

        // Current-value write clears count and flag
        ticks(4, "R6 count to one");
        tick_once(1'b1, "R4 second wrap irq");
        tick_once(1'b0, "R6 refill");
        tick_once(1'b0, "R6 step");
        wr32(8'h08, 32'hDEAD_BEEF, "R6 clear write");
        rd32(8'h08, 32'h0, "R6 count cleared");
        rd32(8'h00, 32'h3, "R6 flag cleared");
        tick_once(1'b0, "R6 reload without flag");
        rd32(8'h08, 32'h5, "R6 reloaded on next tick");

        // Source behaviour
        repeat (10) @(negedge clk);
        rd32(8'h08, 32'h5, "R8 no move without ref strobe");
        ticks(3, "R8 ref strobes");
        rd32(8'h08, 32'h2, "R8 moves per ref strobe");
        wr32(8'h00, 32'h7, "R8 switch to core clock");
        rd32(8'h08, 32'h5, "R8 source switch reloads");
        rd32(8'h08, 32'h4, "R8 core clock steps each cycle");
        wr32(8'h00, 32'h6, "R7 disable");
        rd32(8'h08, 32'h0, "R7 current zero when disabled");
        rd32(8'h00, 32'h6, "R7 status after disable");

        // Rejected accesses
        bus_op(1'b1, 8'h00, 32'h1, 2'd2, 1'b0, 32'h0, 1'b1, "R9 unprivileged write error");
        rd32(8'h00, 32'h6, "R9 status unchanged");
        bus_op(1'b1, 8'h04, 32'h77, 2'd1, 1'b1, 32'h0, 1'b1, "R9 half-size write error");
        rd32(8'h04, 32'h5, "R9 reload unchanged");
        bus_op(1'b0, 8'h0C, 32'h0, 2'd2, 1'b0, 32'h0, 1'b1, "R9 unprivileged read error");

        // Undecoded offsets
        wr32(8'h10, 32'hFFFF_FFFF, "R10 undecoded write");
        rd32(8'h10, 32'h0, "R10 undecoded read zero");
        rd32(8'h00, 32'h6, "R10 status unchanged");
        rd32(8'h04, 32'h5, "R10 reload unchanged");

        // Zero reload never wraps
        wr32(8'h04, 32'h0, "R11 reload zero");
        wr32(8'h00, 32'h7, "R11 enable with zero reload");
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(irq === 1'b0, "R11 no irq with zero reload", {31'h0, irq}, 32'h0);
        end
        rd32(8'h08, 32'h0, "R11 count stays zero");
        rd32(8'h00, 32'h7, "R11 flag never set");

        // Wrap with interrupts disabled
        wr32(8'h00, 32'h0, "R4 disable");
        wr32(8'h04, 32'h2, "R4 reload two");
        wr32(8'h00, 32'h1, "R4 enable without ie");
        tick_once(1'b0, "R4 step");
        tick_once(1'b0, "R4 wrap without irq");
        rd32(8'h00, 32'h0001_0001, "R4 flag set without irq");
        rd32(8'h00, 32'h0000_0001, "R5 flag cleared");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R13 all requests answered", exp_q.size(), 32'h0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule